// File: doc/BRIEF.md
# I2C Repeated-Start Sequencer with Arbitration Check

This block is the master-side sequencer that places a Repeated Start condition on an open-drain I2C bus. A one-cycle request starts it. It first holds SCL low with SDA released for one baud interval, then releases SCL and waits to see the line high. It then keeps both lines high for a second interval, pulls SDA low, and after a third interval pulls SCL low again to finish. The block drives the lines only through drive-low enables. It reads them back through a two-stage synchronizer.

Arbitration against other masters is checked inside the sequence. If SDA is low when SCL is first seen high, another master is sending a 0. If SCL drops during the second interval before this block has pulled SDA low, another master is sending a 1. Either case sets a sticky collision flag, releases both lines and returns the sequencer to idle without a completion pulse. Software clears the flag through a dedicated input, and no new request is accepted until it has done so. An SDA fall caused by another master during the second interval is legal and does not abort the sequence. The SCL level during the third interval is not examined.

Top module: `i2c_rstart_gen`

## Requirements
- R1: After reset both drive-low enables, `done` and `bus_coll` are 0.
- R2: With N = max(reload, 1), an accepted request (sampled at clock edge 0) sets `scl_drive_low`=1 and `sda_drive_low`=0, and `scl_drive_low` returns to 0 after edge N.
- R3: With no contention, `sda_drive_low` becomes 1 after edge 2N+3 and `done` is 1 after edge 3N+3. The +3 consists of two synchronizer stages and one sampling register.
- R4: `done` is high for exactly one cycle. While it is high and afterwards in idle, both drive-low enables remain 1.
- R5: If SDA reads low when SCL is first seen high after the release, `bus_coll` is set after edge N+3.
- R6: If another master pulls SCL low after the negative edge following edge k, during the second interval, `bus_coll` is set after edge k+3.
- R7: SDA pulled low by another master during the second interval causes no collision, and `done` still comes after edge 3N+3.
- R8: SCL pulled low during the third interval causes no collision, and `done` still comes after edge 3N+3.
- R9: When `bus_coll` rises, both drive-low enables are 0 and `done` does not assert for that sequence.
- R10: `bus_coll` stays 1 until `bcl_clr` is 1 at a clock edge, after which it reads 0.
- R11: A request received while a sequence is running is ignored. The running sequence keeps its timing and produces a single `done`.
- R12: A request received while `bus_coll` is 1 is ignored, and both drive-low enables stay 0.
- R13: A reload value of 0 times each interval as one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | One-cycle request to issue a Repeated Start |
| reload | input | RLD_W | Baud interval length in cycles (0 means 1) |
| scl_in | input | 1 | Raw SCL pin level |
| sda_in | input | 1 | Raw SDA pin level |
| bcl_clr | input | 1 | Clears the collision flag |
| scl_drive_low | output | 1 | 1 pulls SCL low |
| sda_drive_low | output | 1 | 1 pulls SDA low |
| done | output | 1 | One-cycle completion pulse |
| bus_coll | output | 1 | Sticky bus-collision flag |

## Verification
Every result is due a fixed number of edges after the request edge. The SCL release comes at N, the SDA pull-down at 2N+3 and `done` at 3N+3. A collision is due at N+3 for a low SDA, or three edges after another master's SCL pull. The bench counts edges from the request edge and samples outputs on each falling edge. It records the first edge at which each output changes and compares that edge number with the value computed from the reload and the forcing edge. Interference from another master is applied on a chosen falling edge, so the three-edge synchronizer latency is part of the expected number.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;
  typedef enum logic [2:0] {
    RS_IDLE,
    RS_CLK_LOW,
    RS_WAIT_HI,
    RS_HOLD_HI,
    RS_HOLD_ST
  } rs_state_t;
endpackage

// File: rtl/i2c_rs_sync.sv
module i2c_rs_sync #(
  parameter int WIDTH   = 2,
  parameter int STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= RST_VAL;
        else     stg[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= RST_VAL;
        else     stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/i2c_rs_baud.sv
module i2c_rs_baud #(
  parameter int RLD_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [RLD_W-1:0] reload,
  output logic             expire
);
  localparam logic [RLD_W-1:0] ONE = RLD_W'(1);

  logic [RLD_W-1:0] cnt;
  logic [RLD_W-1:0] start_val;

  // a zero reload still spends one cycle
  assign start_val = (reload == '0) ? ONE : reload;
  assign expire    = (cnt == ONE);

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= start_val;
    else if (cnt != '0)   cnt <= cnt - ONE;
  end
endmodule

// File: rtl/i2c_rs_fsm.sv
module i2c_rs_fsm
  import i2c_rs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start_req,
  input  logic bcl_clr,
  input  logic scl_s,
  input  logic sda_s,
  input  logic tick,
  output logic load,
  output logic scl_low,
  output logic sda_low,
  output logic done,
  output logic coll
);
  localparam int GW = $clog2(SYNC_STAGES + 1);
  localparam logic [GW-1:0] GUARD_INIT = GW'(SYNC_STAGES);

  rs_state_t    state, state_n;
  logic [GW-1:0] guard, guard_n;
  logic         scl_n, sda_n, done_n, hit;

  always_comb begin
    state_n = state;
    guard_n = (guard != '0) ? guard - GW'(1) : guard;
    load    = 1'b0;
    scl_n   = scl_low;
    sda_n   = sda_low;
    done_n  = 1'b0;
    hit     = 1'b0;
    case (state)
      RS_IDLE: begin
        if (start_req && !coll) begin
          state_n = RS_CLK_LOW;
          load    = 1'b1;
          scl_n   = 1'b1;
          sda_n   = 1'b0;
        end
      end
      RS_CLK_LOW: begin
        if (tick) begin
          state_n = RS_WAIT_HI;
          scl_n   = 1'b0;
          guard_n = GUARD_INIT;
        end
      end
      RS_WAIT_HI: begin
        // values older than the synchronizer depth predate the release
        if (guard == '0 && scl_s) begin
          if (!sda_s) begin
            hit = 1'b1;
          end else begin
            state_n = RS_HOLD_HI;
            load    = 1'b1;
          end
        end
      end
      RS_HOLD_HI: begin
        if (!scl_s) begin
          hit = 1'b1;
        end else if (tick) begin
          state_n = RS_HOLD_ST;
          sda_n   = 1'b1;
          load    = 1'b1;
        end
      end
      RS_HOLD_ST: begin
        if (tick) begin
          state_n = RS_IDLE;
          scl_n   = 1'b1;
          done_n  = 1'b1;
        end
      end
      default: state_n = RS_IDLE;
    endcase
    if (hit) begin
      state_n = RS_IDLE;
      scl_n   = 1'b0;
      sda_n   = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= RS_IDLE;
      guard   <= '0;
      scl_low <= 1'b0;
      sda_low <= 1'b0;
      done    <= 1'b0;
      coll    <= 1'b0;
    end else begin
      state   <= state_n;
      guard   <= guard_n;
      scl_low <= scl_n;
      sda_low <= sda_n;
      done    <= done_n;
      coll    <= hit | (coll & ~bcl_clr);
    end
  end
endmodule

// File: rtl/i2c_rstart_gen.sv
module i2c_rstart_gen #(
  parameter int RLD_W       = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_req,
  input  logic [RLD_W-1:0] reload,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic             bcl_clr,
  output logic             scl_drive_low,
  output logic             sda_drive_low,
  output logic             done,
  output logic             bus_coll
);
  logic [1:0] pins_s;
  logic       tick, load;

  i2c_rs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({scl_in, sda_in}),
    .q   (pins_s)
  );

  i2c_rs_baud #(.RLD_W(RLD_W)) u_baud (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .reload (reload),
    .expire (tick)
  );

  i2c_rs_fsm #(.SYNC_STAGES(SYNC_STAGES)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .start_req (start_req),
    .bcl_clr   (bcl_clr),
    .scl_s     (pins_s[1]),
    .sda_s     (pins_s[0]),
    .tick      (tick),
    .load      (load),
    .scl_low   (scl_drive_low),
    .sda_low   (sda_drive_low),
    .done      (done),
    .coll      (bus_coll)
  );
endmodule

// File: rtl/i2c_rstart_gen_chk.sv
module i2c_rstart_gen_chk (
  input logic clk,
  input logic rst,
  input logic start_req,
  input logic bcl_clr,
  input logic scl_drive_low,
  input logic sda_drive_low,
  input logic done,
  input logic bus_coll
);
  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R4
  done_lines_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (scl_drive_low && sda_drive_low));

  // R9
  coll_release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_coll) |-> (!scl_drive_low && !sda_drive_low && !done));

  // R10
  coll_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_coll && !bcl_clr) |=> bus_coll);

  // R12
  coll_block_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_coll && start_req) |=> ($stable(scl_drive_low) && $stable(sda_drive_low)));
endmodule

bind i2c_rstart_gen i2c_rstart_gen_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .start_req     (start_req),
  .bcl_clr       (bcl_clr),
  .scl_drive_low (scl_drive_low),
  .sda_drive_low (sda_drive_low),
  .done          (done),
  .bus_coll      (bus_coll)
);

// File: tb/i2c_rstart_gen_bench.sv
module i2c_rstart_gen_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_req = 1'b0;
  logic [6:0] reload = '0;
  logic       bcl_clr = 1'b0;
  logic       frc_scl = 1'b0;
  logic       frc_sda = 1'b0;
  logic       scl_drive_low, sda_drive_low, done, bus_coll;
  logic       scl_in, sda_in;

  assign scl_in = !(scl_drive_low | frc_scl);
  assign sda_in = !(sda_drive_low | frc_sda);

  always #5 clk = ~clk;

  i2c_rstart_gen u_i2c_rstart_gen (
    .clk (clk), .rst (rst), .start_req (start_req), .reload (reload),
    .scl_in (scl_in), .sda_in (sda_in), .bcl_clr (bcl_clr),
    .scl_drive_low (scl_drive_low), .sda_drive_low (sda_drive_low),
    .done (done), .bus_coll (bus_coll)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // vector: reload, sda force edge, scl force edge (255 = never), collision, event edge
  localparam int NV = 9;
  localparam logic [40:0] VEC [NV] = '{
    {8'd1,   8'd255, 8'd255, 1'b0, 16'd6},
    {8'd0,   8'd255, 8'd255, 1'b0, 16'd6},
    {8'd4,   8'd255, 8'd255, 1'b0, 16'd15},
    {8'd127, 8'd255, 8'd255, 1'b0, 16'd384},
    {8'd5,   8'd0,   8'd255, 1'b1, 16'd8},
    {8'd10,  8'd255, 8'd15,  1'b1, 16'd18},
    {8'd20,  8'd255, 8'd23,  1'b1, 16'd26},
    {8'd10,  8'd15,  8'd255, 1'b0, 16'd33},
    {8'd10,  8'd255, 8'd25,  1'b0, 16'd33}
  };

  task automatic run_seq(input int rl, input int sda_k, input int scl_k, input int busy_k,
                         output int ev_e, output bit ev_coll, output int rel_e,
                         output int sdl_e, output int done_cnt);
    ev_e = -1; ev_coll = 1'b0; rel_e = -1; sdl_e = -1; done_cnt = 0;
    @(negedge clk);
    reload = 7'(rl);
    start_req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_req = 1'b0;
    if (sda_k == 0) frc_sda = 1'b1;
    if (scl_k == 0) frc_scl = 1'b1;
    for (int e = 1; e < 500; e++) begin
      @(posedge clk);
      @(negedge clk);
      if (done) begin
        done_cnt++;
        if (ev_e < 0) ev_e = e;
      end
      if (bus_coll && ev_e < 0) begin
        ev_e = e;
        ev_coll = 1'b1;
      end
      if (!scl_drive_low && rel_e < 0) rel_e = e;
      if (sda_drive_low && sdl_e < 0) sdl_e = e;
      if (e == sda_k) frc_sda = 1'b1;
      if (e == scl_k) frc_scl = 1'b1;
      start_req = (e == busy_k);
      if (ev_e >= 0 && e > ev_e + 3) break;
    end
    start_req = 1'b0;
    frc_sda = 1'b0;
    frc_scl = 1'b0;
  endtask

  task automatic clear_flag();
    @(negedge clk);
    bcl_clr = 1'b1;
    @(negedge clk);
    bcl_clr = 1'b0;
  endtask

  initial begin
    int ev_e, rel_e, sdl_e, dcnt, n;
    bit ev_coll;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(!scl_drive_low && !sda_drive_low, "R1 lines", {scl_drive_low, sda_drive_low}, 0);
    chk(!done && !bus_coll, "R1 flags", {done, bus_coll}, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      int rl, sk, ck, ee;
      bit ec;
      rl = int'(VEC[v][40:33]);
      sk = int'(VEC[v][32:25]);
      ck = int'(VEC[v][24:17]);
      ec = VEC[v][16];
      ee = int'(VEC[v][15:0]);
      n  = (rl == 0) ? 1 : rl;
      run_seq(rl, sk, ck, -1, ev_e, ev_coll, rel_e, sdl_e, dcnt);
      if (!ec) begin
        // R3 R7 R8 R13 done timing
        chk(ev_e == ee && !ev_coll, "R3/R7/R8/R13 done edge", ev_e, ee);
        chk(rel_e == n, "R2 SCL release edge", rel_e, n);
        chk(sdl_e == 2*n + 3, "R3 SDA pull edge", sdl_e, 2*n + 3);
        chk(dcnt == 1, "R4 done width", dcnt, 1);
        chk(scl_drive_low && sda_drive_low, "R4 idle holds lines", {scl_drive_low, sda_drive_low}, 3);
      end else begin
        // R5 R6 collision edge
        chk(ev_coll && ev_e == ee, "R5/R6 collision edge", ev_e, ee);
        chk(!scl_drive_low && !sda_drive_low, "R9 lines released", {scl_drive_low, sda_drive_low}, 0);
        chk(dcnt == 0, "R9 no done", dcnt, 0);
        repeat (10) @(negedge clk);
        chk(bus_coll, "R10 sticky", bus_coll, 1);
        clear_flag();
        chk(!bus_coll, "R10 cleared", bus_coll, 0);
      end
      repeat (3) @(negedge clk);
    end

    // R11 request during a running sequence
    run_seq(10, 255, 255, 5, ev_e, ev_coll, rel_e, sdl_e, dcnt);
    repeat (40) begin
      @(negedge clk);
      if (done) dcnt++;
    end
    chk(ev_e == 33 && !ev_coll, "R11 done edge", ev_e, 33);
    chk(dcnt == 1, "R11 single done", dcnt, 1);

    // R12 request while flag set
    run_seq(3, 0, 255, -1, ev_e, ev_coll, rel_e, sdl_e, dcnt);
    chk(ev_coll && ev_e == 6, "R5 collision short reload", ev_e, 6);
    @(negedge clk);
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    dcnt = 0;
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      if (done || scl_drive_low || sda_drive_low) dcnt++;
    end
    chk(dcnt == 0, "R12 request ignored", dcnt, 0);
    chk(bus_coll, "R10 still set", bus_coll, 1);
    clear_flag();
    run_seq(2, 255, 255, -1, ev_e, ev_coll, rel_e, sdl_e, dcnt);
    chk(ev_e == 9 && !ev_coll, "R10 accepted after clear", ev_e, 9);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule